// File: doc/BRIEF.md
# Demultiplexing Registered Output Path

This block takes a narrow A input and distributes every A bit over several output columns, producing a wide B bus. With the default sizes a 4-bit A word feeds four columns, giving 16 B outputs. Each B storage cell behaves either as a transparent latch or as an edge-loaded register. Every column has its own latch enable that makes it transparent. A slower device clock, sampled by the system clock, loads exactly one column per rising edge. The column is chosen by a binary select, and the load is gated by a shared active-low clock enable.

The outputs are presented as a data value plus a drive-enable bit per B position, not as pads. A column drives only when the global output enable and that column's own output enable are both asserted (low). A typical use is splitting a time-multiplexed address or data stream into several parallel words, or interleaving writes across banks. Each column is filled in turn as the select advances.

Top module: `demux_reg_out`

## Requirements
- R1: While `rst` is high at a system clock edge, every stored cell clears to 0 and the device-clock history is taken as 1. As a result, a device clock that is already high on the first edge after reset does not count as a rising edge.
- R2: While `col_le[c]` is high, every output of column c equals the matching `a_in` bit in the same cycle. The stored cell also takes `a_in` at each system clock edge where `col_le[c]` is high.
- R3: After `col_le[c]` goes low, column c keeps the `a_in` value sampled at the last system clock edge where `col_le[c]` was high, until something loads it again.
- R4: A device-clock rising edge is `dev_clk` sampled 0 at one system clock edge and 1 at the next. Any load it causes takes effect at that second edge.
- R5: A column with its latch enable low loads `a_in` on a device-clock rising edge only when `clk_en_n` is 0 and `col_sel` equals the column index. Select value 0 addresses column 0 and select value 3 addresses column 3.
- R6: While `clk_en_n` is 1, no column loads on a device-clock edge, and columns whose latch enable is low keep their values.
- R7: Any number of latch enables may be high together, and every such column is transparent at once.
- R8: Output position (i, c) has `b_drive` = 1 only when `oe_all_n` = 0 and `oe_col_n[c]` = 0. When `b_drive` is 0, `b_data` at that position reads 0.
- R9: Slice i takes `a_in[i]`, and its output for column c sits at bit index i*COLS + c of `b_data` and `b_drive`.
- R10: At most one column loads at any system clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | SLICES | A-side data, one bit per slice |
| dev_clk | input | 1 | Device clock, sampled by `clk` |
| clk_en_n | input | 1 | Shared active-low load enable |
| col_sel | input | SEL_W | Binary select of the column to load |
| col_le | input | COLS | Per-column transparent enable, active high |
| oe_all_n | input | 1 | Global output enable, active low |
| oe_col_n | input | COLS | Per-column output enable, active low |
| b_data | output | SLICES*COLS | B data, index slice*COLS + column |
| b_drive | output | SLICES*COLS | B drive enable, same indexing |

## Verification
The bench builds the block with its defaults: four slices and four columns, so the 2-bit select covers all four codes, including the top code 3 that selects the last column. At this size every combination of four latch enables, together with overlapping transparency and per-column output enables, comes up under random stimulus. The device clock is randomized apart from the system clock. This produces back-to-back highs that must not count as edges, and single-cycle pulses that must count.

// File: rtl/demux_pkg.sv
package demux_pkg;

    localparam int DEF_SLICES = 4;
    localparam int DEF_COLS   = 4;

    // Control sampled once per system clock edge, shared by all columns.
    typedef struct packed {
        logic rise;     // device-clock rising edge seen at this edge
        logic cen_n;    // shared active-low load enable
    } load_ctl_t;

    // Width of a binary select covering n columns (at least one bit).
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dmx_edge_detect.sv
module dmx_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic dev_clk,
    output logic rise
);
    logic hist_q;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b1;
        else     hist_q <= dev_clk;
    end

    assign rise = dev_clk & ~hist_q;
endmodule

// File: rtl/dmx_load_decode.sv
module dmx_load_decode
    import demux_pkg::*;
#(
    parameter int COLS  = DEF_COLS,
    parameter int SEL_W = sel_width(COLS)
) (
    input  load_ctl_t        ctl,
    input  logic [SEL_W-1:0] col_sel,
    output logic [COLS-1:0]  load
);
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign load[c] = ctl.rise & ~ctl.cen_n & (col_sel == SEL_W'(c));
    end
endmodule

// File: rtl/dmx_store_col.sv
module dmx_store_col #(
    parameter int SLICES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              le,
    input  logic              load,
    input  logic [SLICES-1:0] d,
    output logic [SLICES-1:0] q
);
    logic [SLICES-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)             held_q <= '0;
        else if (le || load) held_q <= d;
    end

    // Transparency bypasses the stored value.
    assign q = le ? d : held_q;
endmodule

// File: rtl/demux_reg_out.sv
module demux_reg_out
    import demux_pkg::*;
#(
    parameter int SLICES = DEF_SLICES,
    parameter int COLS   = DEF_COLS,
    parameter int SEL_W  = sel_width(COLS),
    localparam int BW    = SLICES * COLS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLICES-1:0] a_in,
    input  logic              dev_clk,
    input  logic              clk_en_n,
    input  logic [SEL_W-1:0]  col_sel,
    input  logic [COLS-1:0]   col_le,
    input  logic              oe_all_n,
    input  logic [COLS-1:0]   oe_col_n,
    output logic [BW-1:0]     b_data,
    output logic [BW-1:0]     b_drive
);
    load_ctl_t         ctl;
    logic              rise;
    logic [COLS-1:0]   load_vec;
    logic [SLICES-1:0] col_q [COLS];

    dmx_edge_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .dev_clk (dev_clk),
        .rise    (rise)
    );

    assign ctl.rise  = rise;
    assign ctl.cen_n = clk_en_n;

    dmx_load_decode #(.COLS(COLS), .SEL_W(SEL_W)) u_dec (
        .ctl     (ctl),
        .col_sel (col_sel),
        .load    (load_vec)
    );

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic col_on;

        dmx_store_col #(.SLICES(SLICES)) u_col (
            .clk  (clk),
            .rst  (rst),
            .le   (col_le[c]),
            .load (load_vec[c]),
            .d    (a_in),
            .q    (col_q[c])
        );

        assign col_on = ~oe_all_n & ~oe_col_n[c];

        for (genvar i = 0; i < SLICES; i++) begin : g_slice
            assign b_drive[i*COLS + c] = col_on;
            assign b_data[i*COLS + c]  = col_on & col_q[c][i];
        end
    end
endmodule

// File: rtl/demux_reg_out_chk.sv
module demux_reg_out_chk #(
    parameter int SLICES = 4,
    parameter int COLS   = 4,
    parameter int SEL_W  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [SLICES-1:0]       a_in,
    input logic                    dev_clk,
    input logic                    clk_en_n,
    input logic [SEL_W-1:0]        col_sel,
    input logic [COLS-1:0]         col_le,
    input logic                    oe_all_n,
    input logic [COLS-1:0]         oe_col_n,
    input logic [SLICES*COLS-1:0]  b_data,
    input logic [SLICES*COLS-1:0]  b_drive,
    input logic [COLS-1:0]         load_vec
);
    // R10
    one_load_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_vec));

    // R4
    load_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|load_vec) |-> (dev_clk && !$past(dev_clk)));

    for (genvar c = 0; c < COLS; c++) begin : g_c
        // R5
        load_addr_chk: assert property (@(posedge clk) disable iff (rst)
            load_vec[c] |-> (!clk_en_n && col_sel == SEL_W'(c)));

        for (genvar i = 0; i < SLICES; i++) begin : g_i
            // R8
            drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
                b_drive[i*COLS+c] == (!oe_all_n && !oe_col_n[c]));

            // R8
            idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
                !b_drive[i*COLS+c] |-> !b_data[i*COLS+c]);

            // R2
            transp_chk: assert property (@(posedge clk) disable iff (rst)
                (col_le[c] && b_drive[i*COLS+c]) |-> b_data[i*COLS+c] == a_in[i]);

            // R6
            hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!col_le[c] && b_drive[i*COLS+c]) &&
                $past(!col_le[c] && clk_en_n && b_drive[i*COLS+c])
                |-> $stable(b_data[i*COLS+c]));
        end
    end
endmodule

bind demux_reg_out demux_reg_out_chk #(
    .SLICES(SLICES), .COLS(COLS), .SEL_W(SEL_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .a_in     (a_in),
    .dev_clk  (dev_clk),
    .clk_en_n (clk_en_n),
    .col_sel  (col_sel),
    .col_le   (col_le),
    .oe_all_n (oe_all_n),
    .oe_col_n (oe_col_n),
    .b_data   (b_data),
    .b_drive  (b_drive),
    .load_vec (load_vec)
);

// File: tb/sim_demux_reg_out.sv
module sim_demux_reg_out;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int NC = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] a_in = '0;
    logic          dev_clk = 1'b0;
    logic          clk_en_n = 1'b1;
    logic [SW-1:0] col_sel = '0;
    logic [NC-1:0] col_le = '0;
    logic          oe_all_n = 1'b0;
    logic [NC-1:0] oe_col_n = '0;
    logic [NS*NC-1:0] b_data, b_drive;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference state: stored value per column, device clock history.
    int ref_st [NC];
    int ref_hist;

    always #(CLK_PERIOD/2) clk = ~clk;

    demux_reg_out u0 (
        .clk(clk), .rst(rst), .a_in(a_in), .dev_clk(dev_clk),
        .clk_en_n(clk_en_n), .col_sel(col_sel), .col_le(col_le),
        .oe_all_n(oe_all_n), .oe_col_n(oe_col_n),
        .b_data(b_data), .b_drive(b_drive)
    );

    // Advance the reference at each system clock edge.
    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NC; c++) ref_st[c] = 0;
            ref_hist = 1;
        end else begin
            bit rising;
            rising = (dev_clk == 1'b1) && (ref_hist == 0);
            for (int c = 0; c < NC; c++) begin
                if (col_le[c]) ref_st[c] = int'(a_in);
                else if (rising && !clk_en_n && int'(col_sel) == c) ref_st[c] = int'(a_in);
            end
            ref_hist = int'(dev_clk);
        end
    end

    task automatic compare(input string tag);
        n_checks++;
        for (int c = 0; c < NC; c++) begin
            for (int i = 0; i < NS; i++) begin
                int idx;
                int edrv;
                int edat;
                idx  = i*NC + c;
                edrv = (!oe_all_n && !oe_col_n[c]) ? 1 : 0;
                edat = 0;
                if (edrv == 1) edat = col_le[c] ? int'(a_in[i]) : ((ref_st[c] >> i) & 1);
                if (int'(b_drive[idx]) != edrv || int'(b_data[idx]) != edat) begin
                    n_fail++;
                    $display("FAIL %s slice %0d col %0d: drive/data got %0d/%0d expected %0d/%0d",
                             tag, i, c, b_drive[idx], b_data[idx], edrv, edat);
                end
            end
        end
    endtask

    // One system clock: let an edge pass, then check after it and after new inputs.
    task automatic tick(input string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic settle(input string tag);
        #1;
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        dev_clk = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1 reset clears");
        rst = 1'b0;
        // R1: dev_clk already high, load enabled on column 0: no load.
        a_in = 4'hF; clk_en_n = 1'b0; col_sel = 2'd0;
        tick("R1 no edge after reset");
        tick("R1 still no edge");

        // R4: low then high gives a load of column 2.
        col_sel = 2'd2; a_in = 4'h5; dev_clk = 1'b0;
        tick("R4 low sample");
        dev_clk = 1'b1;
        tick("R4 rising load");
        a_in = 4'hA;
        tick("R4 high again no reload");

        // R5: each select code loads its own column.
        for (int s = 0; s < NC; s++) begin
            col_sel = SW'(s); a_in = NS'(s + 9); dev_clk = 1'b0;
            tick("R5 prep");
            dev_clk = 1'b1;
            tick("R5 select load");
        end

        // R6: clock enable high blocks loads.
        clk_en_n = 1'b1; col_sel = 2'd1; a_in = 4'h3; dev_clk = 1'b0;
        tick("R6 prep");
        dev_clk = 1'b1;
        tick("R6 no load");

        // R2 and R3: transparency then hold.
        col_le = 4'b0010; a_in = 4'h6;
        settle("R2 transparent");
        a_in = 4'h9;
        settle("R2 follows");
        tick("R2 captured");
        col_le = 4'b0000; a_in = 4'h1;
        settle("R3 hold after fall");
        tick("R3 hold next cycle");

        // R7: all columns transparent.
        col_le = 4'b1111; a_in = 4'hC;
        settle("R7 all transparent");
        tick("R7 captured all");
        col_le = '0; a_in = 4'h0;
        settle("R7 all hold");

        // R8 and R9: output enable combinations.
        oe_col_n = 4'b0101;
        settle("R8 partial enable R9 mapping");
        oe_all_n = 1'b1;
        settle("R8 global off");
        oe_all_n = 1'b0; oe_col_n = '0;
        settle("R8 all on");

        // R10: random traffic, checked every cycle.
        for (int k = 0; k < 3000; k++) begin
            a_in     = NS'($urandom);
            dev_clk  = 1'($urandom);
            clk_en_n = ($urandom % 4) == 0;
            col_sel  = SW'($urandom);
            col_le   = (($urandom % 3) == 0) ? NC'($urandom) : '0;
            oe_all_n = ($urandom % 8) == 0;
            oe_col_n = (($urandom % 4) == 0) ? NC'($urandom) : '0;
            settle("R10 random inputs");
            tick("R10 random edge");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule